// File: doc/BRIEF.md
# Processor Interrupt Presentation Controller

This block sits beside one processor and decides which interrupt, if any, is offered to it. It keeps four pieces of state: the processor's current priority, the priority of a software-raised inter-processor interrupt (IPI), a single pending slot (a source id with its priority), and a flag that records that some source was turned away and must be offered again later. All priorities are 8 bits wide, and a smaller number is more urgent.

The processor drives four operations: accept, write current priority, write IPI priority, and end-of-interrupt. A source controller outside this block offers interrupts, each as an id with a priority. The block drives an interrupt request. It also emits single-cycle pulses that tell the source side which id it displaced (reject), that deferred sources should be offered again (resend), and which id has finished (EOI). A sideband input tells the block whether the level source being ended is still active.

Top module: `ipc_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the IPI priority is 0xFF, the pending slot is empty (id 0, priority 0xFF), the resend flag is clear, the request output is low and no pulse is active.
- R2: `irq_o` is high exactly when the pending id is nonzero and the pending priority is strictly below the current priority.
- R3: `acc_word_o` always shows the current priority in bits 31:24 and the pending id in bits 23:0. An accept with a nonzero pending id moves the pending priority into the current priority, sets the pending priority to 0xFF and clears the id. An accept with id 0 changes nothing.
- R4: An IPI priority write below the current priority makes the IPI (id 2) pending at the written priority. The displaced id is rejected only when the written value is at or below the old pending priority.
- R5: An IPI priority write that is above both the old IPI priority and the current priority emits the resend flag as a pulse and clears the flag.
- R6: A current priority write equal to the present value changes no state and emits no pulse.
- R7: A current priority write above the present value loads it. If the IPI priority is then below the new value and at or below the pending priority, the IPI becomes pending. The resend flag is emitted as a pulse and cleared.
- R8: A current priority write below the present value loads it. If the new value is at or below the pending priority, the pending id is rejected and the slot is emptied.
- R9: An end-of-interrupt write carries the new current priority in bits 31:24 and the ended id in bits 23:0, and it performs the update of R7. An EOI pulse carrying the id is emitted unless the id is 0 or 2.
- R10: If the level-active sideband is high during an end-of-interrupt, the ended id is re-offered by emitting a reject for it.
- R11: No reject pulse is ever emitted for id 0 or id 2.
- R12: An offered interrupt is taken only when its priority is below both the current and the pending priority, and the displaced id is rejected. Otherwise the offered id is rejected and the resend flag is set.
- R13: Each operation updates state at one clock edge. Its pulses appear in the next cycle and last a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Accept strobe |
| acc_word_o | output | 32 | Current priority and pending id, read at accept |
| cppr_we_i | input | 1 | Current priority write strobe |
| cppr_i | input | 8 | Current priority write value |
| mfrr_we_i | input | 1 | IPI priority write strobe |
| mfrr_i | input | 8 | IPI priority write value |
| eoi_we_i | input | 1 | End-of-interrupt strobe |
| eoi_word_i | input | 32 | New current priority (31:24) and ended id (23:0) |
| lvl_active_i | input | 1 | Ended level source is still active |
| pres_valid_i | input | 1 | Source controller offers an interrupt |
| pres_id_i | input | 24 | Offered id |
| pres_pri_i | input | 8 | Offered priority |
| irq_o | output | 1 | Interrupt request to the processor |
| reject_o | output | 1 | Reject pulse |
| reject_id_o | output | 24 | Rejected id |
| resend_o | output | 1 | Resend pulse |
| eoi_o | output | 1 | EOI pulse toward the source side |
| eoi_id_o | output | 24 | Ended id |

## Verification
The assertions assume that at most one of the five operation strobes is high in any cycle. The block resolves a collision by fixed priority, and the properties are written for one operation per cycle. The bench drives exactly one strobe per step, with idle steps in between, and offers interrupts only with nonzero ids. Priorities are drawn from a small set (0 to 5, 0xFE, 0xFF) so that the equal and adjacent comparisons occur often.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned PRI_W  = 8;
  localparam int unsigned ID_W   = 24;
  localparam int unsigned WORD_W = PRI_W + ID_W;
  localparam logic [PRI_W-1:0] PRI_NONE = '1;

  typedef struct packed {
    logic [PRI_W-1:0] cppr;
    logic [PRI_W-1:0] mfrr;
    logic [PRI_W-1:0] pri;
    logic [ID_W-1:0]  id;
    logic             nr;
  } ipc_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_ACC, OP_EOI, OP_CPPR, OP_MFRR, OP_PRES
  } ipc_op_e;
endpackage

// File: rtl/ipc_op_decode.sv
module ipc_op_decode
  import ipc_pkg::*;
(
  input  logic    acc_i,
  input  logic    eoi_we_i,
  input  logic    cppr_we_i,
  input  logic    mfrr_we_i,
  input  logic    pres_valid_i,
  output ipc_op_e op_o
);
  // fixed priority if strobes collide
  always_comb begin
    if (acc_i)             op_o = OP_ACC;
    else if (eoi_we_i)     op_o = OP_EOI;
    else if (cppr_we_i)    op_o = OP_CPPR;
    else if (mfrr_we_i)    op_o = OP_MFRR;
    else if (pres_valid_i) op_o = OP_PRES;
    else                   op_o = OP_NONE;
  end
endmodule

// File: rtl/ipc_next.sv
module ipc_next
  import ipc_pkg::*;
#(
  parameter logic [ID_W-1:0] IPI_ID = 24'd2
) (
  input  ipc_state_t        cur_i,
  input  ipc_op_e           op_i,
  input  logic [PRI_W-1:0]  cppr_i,
  input  logic [PRI_W-1:0]  mfrr_i,
  input  logic [WORD_W-1:0] eoi_word_i,
  input  logic              lvl_active_i,
  input  logic [ID_W-1:0]   pres_id_i,
  input  logic [PRI_W-1:0]  pres_pri_i,
  output ipc_state_t        nxt_o,
  output logic              rej_o,
  output logic [ID_W-1:0]   rej_id_o,
  output logic              rs_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  logic [PRI_W-1:0] dn_cppr;
  logic [ID_W-1:0]  eoi_src;
  logic             dn_ipi;
  logic             rej_raw;
  logic [ID_W-1:0]  rej_raw_id;

  assign eoi_src = eoi_word_i[ID_W-1:0];
  assign dn_cppr = (op_i == OP_EOI) ? eoi_word_i[WORD_W-1:ID_W] : cppr_i;
  // IPI takes the slot when lowering priority if it beats the new level
  assign dn_ipi  = (cur_i.mfrr < dn_cppr) && (cur_i.mfrr <= cur_i.pri);

  always_comb begin
    nxt_o      = cur_i;
    rej_raw    = 1'b0;
    rej_raw_id = '0;
    rs_o       = 1'b0;
    eoi_o      = 1'b0;
    eoi_id_o   = '0;
    unique case (op_i)
      OP_ACC: begin
        if (cur_i.id != '0) begin
          nxt_o.cppr = cur_i.pri;
          nxt_o.pri  = PRI_NONE;
          nxt_o.id   = '0;
        end
      end
      OP_CPPR: begin
        if (cppr_i > cur_i.cppr) begin
          nxt_o.cppr = dn_cppr;
          if (dn_ipi) begin
            nxt_o.pri = cur_i.mfrr;
            nxt_o.id  = IPI_ID;
          end
          rs_o     = cur_i.nr;
          nxt_o.nr = 1'b0;
        end else if (cppr_i < cur_i.cppr) begin
          nxt_o.cppr = cppr_i;
          if (cppr_i <= cur_i.pri) begin
            rej_raw    = 1'b1;
            rej_raw_id = cur_i.id;
            nxt_o.id   = '0;
            nxt_o.pri  = PRI_NONE;
          end
        end
      end
      OP_MFRR: begin
        nxt_o.mfrr = mfrr_i;
        if (mfrr_i < cur_i.cppr) begin
          if (mfrr_i <= cur_i.pri) begin
            rej_raw    = 1'b1;
            rej_raw_id = cur_i.id;
          end
          nxt_o.pri = mfrr_i;
          nxt_o.id  = IPI_ID;
        end
        if ((mfrr_i > cur_i.mfrr) && (mfrr_i > cur_i.cppr)) begin
          rs_o     = cur_i.nr;
          nxt_o.nr = 1'b0;
        end
      end
      OP_EOI: begin
        nxt_o.cppr = dn_cppr;
        if (dn_ipi) begin
          nxt_o.pri = cur_i.mfrr;
          nxt_o.id  = IPI_ID;
        end
        rs_o     = cur_i.nr;
        nxt_o.nr = 1'b0;
        if ((eoi_src != IPI_ID) && (eoi_src != '0)) begin
          eoi_o    = 1'b1;
          eoi_id_o = eoi_src;
        end
        if (lvl_active_i) begin
          rej_raw    = 1'b1;
          rej_raw_id = eoi_src;
        end
      end
      OP_PRES: begin
        if ((pres_pri_i < cur_i.cppr) && (pres_pri_i < cur_i.pri)) begin
          rej_raw    = 1'b1;
          rej_raw_id = cur_i.id;
          nxt_o.pri  = pres_pri_i;
          nxt_o.id   = pres_id_i;
        end else begin
          rej_raw    = 1'b1;
          rej_raw_id = pres_id_i;
          nxt_o.nr   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign rej_o    = rej_raw && (rej_raw_id != '0) && (rej_raw_id != IPI_ID);
  assign rej_id_o = rej_o ? rej_raw_id : '0;
endmodule

// File: rtl/ipc_pulse_reg.sv
module ipc_pulse_reg
  import ipc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rej_i,
  input  logic [ID_W-1:0] rej_id_i,
  input  logic            rs_i,
  input  logic            eoi_i,
  input  logic [ID_W-1:0] eoi_id_i,
  output logic            rej_o,
  output logic [ID_W-1:0] rej_id_o,
  output logic            rs_o,
  output logic            eoi_o,
  output logic [ID_W-1:0] eoi_id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rej_o    <= 1'b0;
      rej_id_o <= '0;
      rs_o     <= 1'b0;
      eoi_o    <= 1'b0;
      eoi_id_o <= '0;
    end else begin
      rej_o    <= rej_i;
      rej_id_o <= rej_id_i;
      rs_o     <= rs_i;
      eoi_o    <= eoi_i;
      eoi_id_o <= eoi_id_i;
    end
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
  import ipc_pkg::*;
#(
  parameter logic [ID_W-1:0] IPI_ID = 24'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  output logic [WORD_W-1:0] acc_word_o,
  input  logic              cppr_we_i,
  input  logic [PRI_W-1:0]  cppr_i,
  input  logic              mfrr_we_i,
  input  logic [PRI_W-1:0]  mfrr_i,
  input  logic              eoi_we_i,
  input  logic [WORD_W-1:0] eoi_word_i,
  input  logic              lvl_active_i,
  input  logic              pres_valid_i,
  input  logic [ID_W-1:0]   pres_id_i,
  input  logic [PRI_W-1:0]  pres_pri_i,
  output logic              irq_o,
  output logic              reject_o,
  output logic [ID_W-1:0]   reject_id_o,
  output logic              resend_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  ipc_state_t      st_q, st_d;
  ipc_op_e         op;
  logic            rej_c, rs_c, eoi_c;
  logic [ID_W-1:0] rej_id_c, eoi_id_c;

  ipc_op_decode u_dec (
    .acc_i        (acc_i),
    .eoi_we_i     (eoi_we_i),
    .cppr_we_i    (cppr_we_i),
    .mfrr_we_i    (mfrr_we_i),
    .pres_valid_i (pres_valid_i),
    .op_o         (op)
  );

  ipc_next #(.IPI_ID(IPI_ID)) u_next (
    .cur_i        (st_q),
    .op_i         (op),
    .cppr_i       (cppr_i),
    .mfrr_i       (mfrr_i),
    .eoi_word_i   (eoi_word_i),
    .lvl_active_i (lvl_active_i),
    .pres_id_i    (pres_id_i),
    .pres_pri_i   (pres_pri_i),
    .nxt_o        (st_d),
    .rej_o        (rej_c),
    .rej_id_o     (rej_id_c),
    .rs_o         (rs_c),
    .eoi_o        (eoi_c),
    .eoi_id_o     (eoi_id_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.cppr <= '0;
      st_q.mfrr <= PRI_NONE;
      st_q.pri  <= PRI_NONE;
      st_q.id   <= '0;
      st_q.nr   <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  ipc_pulse_reg u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rej_i    (rej_c),
    .rej_id_i (rej_id_c),
    .rs_i     (rs_c),
    .eoi_i    (eoi_c),
    .eoi_id_i (eoi_id_c),
    .rej_o    (reject_o),
    .rej_id_o (reject_id_o),
    .rs_o     (resend_o),
    .eoi_o    (eoi_o),
    .eoi_id_o (eoi_id_o)
  );

  assign irq_o      = (st_q.id != '0) && (st_q.pri < st_q.cppr);
  assign acc_word_o = {st_q.cppr, st_q.id};
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
  import ipc_pkg::*;
#(
  parameter logic [ID_W-1:0] IPI_ID = 24'd2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic [WORD_W-1:0] acc_word_o,
  input logic              cppr_we_i,
  input logic [PRI_W-1:0]  cppr_i,
  input logic              mfrr_we_i,
  input logic [PRI_W-1:0]  mfrr_i,
  input logic              eoi_we_i,
  input logic              pres_valid_i,
  input logic              irq_o,
  input logic              reject_o,
  input logic [ID_W-1:0]   reject_id_o,
  input logic              resend_o,
  input logic              eoi_o,
  input logic [ID_W-1:0]   eoi_id_o
);
  // R13 input assumption: one operation per cycle
  a_r13_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_i, cppr_we_i, mfrr_we_i, eoi_we_i, pres_valid_i}));

  a_r3_accept_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && acc_word_o[ID_W-1:0] != '0) |=> (!irq_o && acc_word_o[ID_W-1:0] == '0));

  a_r4_ipi_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mfrr_we_i && mfrr_i < acc_word_o[WORD_W-1:ID_W]) |=>
      (acc_word_o[ID_W-1:0] == IPI_ID && !resend_o));

  a_r6_equal_cppr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cppr_we_i && cppr_i == acc_word_o[WORD_W-1:ID_W]) |=>
      ($stable(acc_word_o) && !reject_o && !resend_o));

  a_r11_reject_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (reject_id_o != '0 && reject_id_o != IPI_ID));

  a_r9_eoi_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> (eoi_id_o != '0 && eoi_id_o != IPI_ID));
endmodule

bind ipc_presenter ipc_checker #(.IPI_ID(IPI_ID)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_i        (acc_i),
  .acc_word_o   (acc_word_o),
  .cppr_we_i    (cppr_we_i),
  .cppr_i       (cppr_i),
  .mfrr_we_i    (mfrr_we_i),
  .mfrr_i       (mfrr_i),
  .eoi_we_i     (eoi_we_i),
  .pres_valid_i (pres_valid_i),
  .irq_o        (irq_o),
  .reject_o     (reject_o),
  .reject_id_o  (reject_id_o),
  .resend_o     (resend_o),
  .eoi_o        (eoi_o),
  .eoi_id_o     (eoi_id_o)
);

// File: tb/ipc_presenter_bench.sv
module ipc_presenter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic [31:0] acc_word_o;
  logic        cppr_we_i = 1'b0;
  logic [7:0]  cppr_i = '0;
  logic        mfrr_we_i = 1'b0;
  logic [7:0]  mfrr_i = '0;
  logic        eoi_we_i = 1'b0;
  logic [31:0] eoi_word_i = '0;
  logic        lvl_active_i = 1'b0;
  logic        pres_valid_i = 1'b0;
  logic [23:0] pres_id_i = '0;
  logic [7:0]  pres_pri_i = '0;
  logic        irq_o, reject_o, resend_o, eoi_o;
  logic [23:0] reject_id_o, eoi_id_o;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ipc_presenter u_ipc_presenter (.*);

  // reference state
  logic [7:0]  m_cppr = 8'h00, m_mfrr = 8'hFF, m_pri = 8'hFF;
  logic [23:0] m_id = '0;
  logic        m_nr = 1'b0;
  logic        e_rej, e_rs, e_eoi;
  logic [23:0] e_rej_id, e_eoi_id;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void mrej(input logic [23:0] x);
    if (x != 24'd0 && x != 24'd2) begin e_rej = 1'b1; e_rej_id = x; end
  endfunction

  function automatic void mdown(input logic [7:0] c);
    logic [7:0] p0;
    p0 = m_pri;
    m_cppr = c;
    if (m_mfrr < c && m_mfrr <= p0) begin m_pri = m_mfrr; m_id = 24'd2; end
    e_rs = m_nr;
    m_nr = 1'b0;
  endfunction

  // op: 0 idle, 1 accept, 2 cppr, 3 mfrr, 4 eoi, 5 present
  task automatic step(input int op, input logic [7:0] pv, input logic [23:0] idv, input logic lvl);
    string tag;
    logic [7:0] old;
    e_rej = 0; e_rej_id = '0; e_rs = 0; e_eoi = 0; e_eoi_id = '0;
    tag = "R13";
    case (op)
      1: begin
        tag = "R3";
        acc_i = 1'b1;
        #1 chk("R3 accept word", acc_word_o, {m_cppr, m_id});
        if (m_id != 0) begin m_cppr = m_pri; m_pri = 8'hFF; m_id = '0; end
      end
      2: begin
        cppr_we_i = 1'b1; cppr_i = pv;
        if (pv > m_cppr) begin tag = "R7"; mdown(pv); end
        else if (pv < m_cppr) begin
          tag = "R8";
          m_cppr = pv;
          if (pv <= m_pri) begin mrej(m_id); m_id = '0; m_pri = 8'hFF; end
        end else tag = "R6";
      end
      3: begin
        tag = "R4/R5";
        mfrr_we_i = 1'b1; mfrr_i = pv;
        old = m_mfrr; m_mfrr = pv;
        if (pv < m_cppr) begin
          if (pv <= m_pri) mrej(m_id);
          m_pri = pv; m_id = 24'd2;
        end
        if (pv > old && pv > m_cppr) begin e_rs = m_nr; m_nr = 1'b0; end
      end
      4: begin
        tag = "R9/R10";
        eoi_we_i = 1'b1; eoi_word_i = {pv, idv}; lvl_active_i = lvl;
        mdown(pv);
        if (idv != 0 && idv != 24'd2) begin e_eoi = 1'b1; e_eoi_id = idv; end
        if (lvl) mrej(idv);
      end
      5: begin
        tag = "R12";
        pres_valid_i = 1'b1; pres_id_i = idv; pres_pri_i = pv;
        if (pv < m_cppr && pv < m_pri) begin mrej(m_id); m_pri = pv; m_id = idv; end
        else begin mrej(idv); m_nr = 1'b1; end
      end
      default: ;
    endcase
    @(posedge clk_i);
    @(negedge clk_i);
    acc_i = 0; cppr_we_i = 0; mfrr_we_i = 0; eoi_we_i = 0; pres_valid_i = 0; lvl_active_i = 0;
    chk({tag, " state word"}, acc_word_o, {m_cppr, m_id});
    chk({tag, " R2 irq"}, {31'd0, irq_o}, {31'd0, (m_id != 0) && (m_pri < m_cppr)});
    chk({tag, " R11 reject"}, {7'd0, reject_o, reject_id_o}, {7'd0, e_rej, e_rej_id});
    chk({tag, " resend"}, {31'd0, resend_o}, {31'd0, e_rs});
    chk({tag, " eoi"}, {7'd0, eoi_o, eoi_id_o}, {7'd0, e_eoi, e_eoi_id});
  endtask

  function automatic logic [7:0] pick_pri(input logic [2:0] r);
    case (r)
      3'd6: return 8'hFE;
      3'd7: return 8'hFF;
      default: return {5'd0, r};
    endcase
  endfunction

  initial begin
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 word", acc_word_o, 32'd0);
    chk("R1 pulses", {28'd0, irq_o, reject_o, resend_o, eoi_o}, 32'd0);
    // directed corners
    step(2, 8'hFF, 0, 0);           // R7 lower priority, IPI at 0xFF not taken
    step(5, 8'hFE, 24'h7, 0);       // R12 taken, irq high
    step(5, 8'hFE, 24'h9, 0);       // R12 equal priority refused, resend set
    step(2, 8'hFF, 0, 0);           // R6 equal no effect
    step(1, 0, 0, 0);               // R3 accept
    step(1, 0, 0, 0);               // R3 accept with empty slot
    step(3, 8'h03, 0, 0);           // R4 IPI pending below cppr
    step(2, 8'h03, 0, 0);           // R8 up to IPI level, IPI reject suppressed
    step(3, 8'hFF, 0, 0);           // R5 resend
    step(4, 8'hFF, 24'h7, 1);       // R9 R10 eoi with level re-offer
    step(4, 8'hFF, 24'h2, 1);       // R9 R11 IPI id: no eoi, no reject
    step(0, 0, 0, 0);               // R13 pulses gone
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [23:0] idv;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op = int'(lf[10:8]) % 6;
      case (lf[13:12])
        2'd0: idv = 24'h7;
        2'd1: idv = 24'h12345;
        2'd2: idv = (op == 5) ? 24'h9 : 24'h2;
        default: idv = 24'hFFFFFF;
      endcase
      if (op == 4 && lf[15:14] == 2'd0) idv = 24'h0;
      step(op, pick_pri(lf[2:0]), idv, lf[5]);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      vec++; bad++;
      $display("FAIL R13 watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule